// File: doc/BRIEF.md
# Redundancy Trailer Handler for a Dual-LAN Frame Path

This block sits in the frame path of a box that joins single-homed equipment to two parallel, independent LANs. Frames enter as a byte stream with the frame check sequence already removed. Each frame leaves as a byte stream on two outputs, A and B, one per LAN. A frame that comes from the local CPU port (source port 0) gets a six-byte redundancy trailer appended. The trailer holds a sequence number shared by both copies, a LAN identifier that differs per copy, the service data size and a fixed 16-bit suffix.

A frame that comes from a LAN port may already carry a trailer. Its last six bytes are held back in a small register until the frame ends. The decision is made then. If the last two bytes equal the suffix, the held trailer is sent on unchanged. If they do not, the sender was a single-homed node: the held bytes are dropped and a new trailer is built in their place. A CRC-32 is always computed over the bytes sent and appended. In redundancy mode the block then issues a duplicate lookup keyed by source MAC and sequence number, and turns the answer into a per-frame drop verdict. A bypass mode skips all trailer work and sends the frame, with a new CRC, to output A only.

Top module: `prp_trailer_handler`

## Requirements
- R1: After reset, in_ready_o is 1 and out_a_valid_o, out_b_valid_o, lkp_req_o and verdict_valid_o are all 0.
- R2: A frame from source port 0 with bypass off is sent on both outputs as its bytes unchanged, then six trailer bytes in this order: sequence high, sequence low, {LAN id, size[11:8]}, size[7:0], 0x88, 0xFB. The LAN id is 0xA on output A and 0xB on output B.
- R3: The sequence counter starts at 1 after reset. It advances by one for each newly built trailer, and both copies carry the same value.
- R4: The size field of a newly built trailer equals (forwarded frame bytes + 4) modulo 4096.
- R5: A frame from a nonzero source port whose length is at least 6 and whose last two bytes are 0x88, 0xFB is sent on both outputs with all its bytes unchanged, and the sequence counter does not advance.
- R6: A frame from a nonzero source port that does not meet R5 loses its last min(6, length) bytes. The rest is forwarded on both outputs, followed by a newly built trailer as in R2.
- R7: Every output frame ends with four CRC bytes. The CRC is CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, result inverted) over all bytes sent before it on that output, least significant byte first. The last flag is set on the final CRC byte only.
- R8: With bypass off, after the last CRC byte lkp_req_o rises with lkp_key_o = {source MAC, sequence}. The sequence is the one carried by the trailer that was sent. lkp_req_o stays high until lkp_done_i.
- R9: One cycle after lkp_done_i is seen with lkp_req_o high, verdict_valid_o pulses for one cycle with verdict_drop_o equal to lkp_hit_i.
- R10: With bypass on, the frame is sent unchanged on output A followed by its CRC. Output B stays silent, no lookup or verdict occurs, and the sequence counter does not advance.
- R11: in_ready_o is 0 from the cycle after the last input byte is accepted until the frame's tail, lookup and verdict are complete.
- R12: Source port, source MAC and bypass are sampled with the first byte of a frame. Their values during later bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | 1: pass frame to output A with CRC only |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of a frame |
| src_port_i | input | 3 | Ingress port of the frame, 0 is the local CPU |
| src_mac_i | input | 48 | Source MAC of the frame |
| out_a_valid_o | output | 1 | Output A byte valid |
| out_a_data_o | output | 8 | Output A byte |
| out_a_last_o | output | 1 | Output A final byte |
| out_b_valid_o | output | 1 | Output B byte valid |
| out_b_data_o | output | 8 | Output B byte |
| out_b_last_o | output | 1 | Output B final byte |
| lkp_req_o | output | 1 | Duplicate lookup request |
| lkp_key_o | output | 64 | Lookup key {source MAC, sequence} |
| lkp_done_i | input | 1 | Lookup answer valid |
| lkp_hit_i | input | 1 | Lookup found the pair already present |
| verdict_valid_o | output | 1 | Per-frame verdict pulse |
| verdict_drop_o | output | 1 | 1: frame is a duplicate and must be dropped |

## Verification
The bench drives four kinds of frame: CPU frames, LAN frames ending in a genuine trailer, LAN frames with no or a near-miss suffix, and bypass frames. Each kind separates one of the three end-of-frame outcomes (append a trailer, keep the held bytes, drop them and append) from the others. Short frames of one to six bytes test how the hold register behaves when it is partly filled or exactly full. Long frames test the sliding delay. Lookup answers alternate between hit and miss so that the verdict is seen to follow the answer. Source port and MAC toggle randomly after the first byte, which shows they are sampled only once.

// File: rtl/prp_pkg.sv
`timescale 1ns/1ps
package prp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SEQ_W     = 16;
  localparam int unsigned LSDU_W    = 12;
  localparam int unsigned LAN_W     = 4;
  localparam int unsigned TRL_BYTES = 6;
  localparam int unsigned CRC_BYTES = 4;
  localparam int unsigned CRC_W     = 32;
  localparam logic [15:0]       SUFFIX   = 16'h88FB;
  localparam logic [LAN_W-1:0]  LAN_A_ID = 4'hA;
  localparam logic [LAN_W-1:0]  LAN_B_ID = 4'hB;
  localparam logic [CRC_W-1:0]  CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_RX, ST_EVAL, ST_FLUSH, ST_TRL, ST_CRC, ST_LKP
  } tail_st_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int i = 0; i < BYTE_W; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] trl_byte(input logic [2:0] idx,
                                                 input logic [SEQ_W-1:0] seq,
                                                 input logic [LSDU_W-1:0] lsdu,
                                                 input logic [LAN_W-1:0] lan);
    case (idx)
      3'd0:    return seq[15:8];
      3'd1:    return seq[7:0];
      3'd2:    return {lan, lsdu[11:8]};
      3'd3:    return lsdu[7:0];
      3'd4:    return SUFFIX[15:8];
      default: return SUFFIX[7:0];
    endcase
  endfunction
endpackage

// File: rtl/prp_hold_buf.sv
`timescale 1ns/1ps
// Sliding window of the newest DEPTH bytes; slot 0 is the oldest.
module prp_hold_buf #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned W  = DEPTH * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    byte_i,
  output logic          full_o,
  output logic [CW-1:0] cnt_o,
  output logic [7:0]    head_o,
  output logic [W-1:0]  bytes_o
);
  logic [W-1:0]  win_q, win_d;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign head_o  = win_q[7:0];
  assign bytes_o = win_q;

  always_comb begin
    win_d = win_q;
    if (full_o) win_d = {byte_i, win_q[W-1:8]};
    else begin
      for (int i = 0; i < DEPTH; i++)
        if (int'(cnt_q) == i) win_d[i*8 +: 8] = byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      win_q <= win_d;
      if (!full_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/prp_crc_acc.sv
`timescale 1ns/1ps
module prp_crc_acc
  import prp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] fcs_o
);
  logic [CRC_W-1:0] crc_q;

  assign fcs_o = ~crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (clr_i)  crc_q <= '1;
    else if (upd_i)  crc_q <= crc_step(crc_q, byte_i);
  end
endmodule

// File: rtl/prp_trailer_handler.sv
`timescale 1ns/1ps
module prp_trailer_handler
  import prp_pkg::*;
#(
  parameter int unsigned MAC_W  = 48,
  parameter int unsigned PORT_W = 3,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned HCW   = $clog2(TRL_BYTES + 1),
  localparam int unsigned KEY_W = MAC_W + SEQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  input  logic [PORT_W-1:0] src_port_i,
  input  logic [MAC_W-1:0]  src_mac_i,
  output logic              out_a_valid_o,
  output logic [7:0]        out_a_data_o,
  output logic              out_a_last_o,
  output logic              out_b_valid_o,
  output logic [7:0]        out_b_data_o,
  output logic              out_b_last_o,
  output logic              lkp_req_o,
  output logic [KEY_W-1:0]  lkp_key_o,
  input  logic              lkp_done_i,
  input  logic              lkp_hit_i,
  output logic              verdict_valid_o,
  output logic              verdict_drop_o
);
  tail_st_e st_q;
  logic [2:0]        idx_q, flush_n_q;
  logic              first_q, bypass_q, gen_q;
  logic [PORT_W-1:0] src_q;
  logic [MAC_W-1:0]  mac_q;
  logic [CNT_W-1:0]  pay_cnt_q;
  logic [SEQ_W-1:0]  seq_ctr_q, seq_use_q;
  logic [LSDU_W-1:0] lsdu_q;

  logic              accept, tail_done, emit, is_last;
  logic              hold_full;
  logic [HCW-1:0]    hold_cnt;
  logic [7:0]        hold_head;
  logic [TRL_BYTES*8-1:0] hold_bytes;
  logic [7:0]        emit_byte [2];
  logic [CRC_W-1:0]  fcs [2];
  logic [LAN_W-1:0]  lan_id [2];

  assign in_ready_o = (st_q == ST_RX);
  assign accept     = in_valid_i && in_ready_o;
  assign tail_done  = (st_q == ST_CRC) && (idx_q == 3'(CRC_BYTES - 1));
  assign lkp_req_o  = (st_q == ST_LKP);
  assign lkp_key_o  = {mac_q, seq_use_q};
  assign lan_id[0]  = LAN_A_ID;
  assign lan_id[1]  = LAN_B_ID;

  prp_hold_buf #(.DEPTH(TRL_BYTES)) u_hold (
    .clk_i, .rst_ni, .clr_i(tail_done), .push_i(accept), .byte_i(in_data_i),
    .full_o(hold_full), .cnt_o(hold_cnt), .head_o(hold_head), .bytes_o(hold_bytes)
  );

  // one CRC engine per LAN copy: built trailers differ in the LAN nibble
  for (genvar g = 0; g < 2; g++) begin : g_lan
    prp_crc_acc u_crc (
      .clk_i, .rst_ni, .clr_i(tail_done), .upd_i(emit && (st_q != ST_CRC)),
      .byte_i(emit_byte[g]), .fcs_o(fcs[g])
    );
    always_comb begin
      case (st_q)
        ST_FLUSH: emit_byte[g] = hold_bytes[idx_q*8 +: 8];
        ST_TRL:   emit_byte[g] = trl_byte(idx_q, seq_use_q, lsdu_q, lan_id[g]);
        ST_CRC:   emit_byte[g] = fcs[g][idx_q*8 +: 8];
        default:  emit_byte[g] = hold_head;
      endcase
    end
  end

  always_comb begin
    emit    = 1'b0;
    is_last = 1'b0;
    case (st_q)
      ST_RX:    emit = accept && hold_full;
      ST_FLUSH: emit = 1'b1;
      ST_TRL:   emit = 1'b1;
      ST_CRC: begin emit = 1'b1; is_last = tail_done; end
      default: ;
    endcase
  end

  // end-of-frame evaluation on the settled hold window
  logic             sfx_ok, ev_cpu, ev_gen;
  logic [2:0]       ev_flush;
  logic [CNT_W-1:0] ev_payload;
  always_comb begin
    sfx_ok = (hold_cnt == HCW'(TRL_BYTES)) &&
             (hold_bytes[4*8 +: 8] == SUFFIX[15:8]) &&
             (hold_bytes[5*8 +: 8] == SUFFIX[7:0]);
    ev_cpu = (src_q == '0);
    if (bypass_q || ev_cpu || sfx_ok) begin
      ev_flush   = 3'(hold_cnt);
      ev_gen     = !bypass_q && ev_cpu;
      ev_payload = pay_cnt_q + CNT_W'(hold_cnt);
    end else begin
      ev_flush   = '0;
      ev_gen     = 1'b1;
      ev_payload = pay_cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RX; idx_q <= '0; flush_n_q <= '0;
      first_q <= 1'b1; bypass_q <= 1'b0; gen_q <= 1'b0;
      src_q <= '0; mac_q <= '0; pay_cnt_q <= '0;
      seq_ctr_q <= SEQ_W'(1); seq_use_q <= '0; lsdu_q <= '0;
      verdict_valid_o <= 1'b0; verdict_drop_o <= 1'b0;
    end else begin
      verdict_valid_o <= 1'b0;
      if (accept) begin
        first_q <= in_last_i;
        if (first_q) begin
          bypass_q <= bypass_i; src_q <= src_port_i; mac_q <= src_mac_i;
        end
        if (hold_full) pay_cnt_q <= pay_cnt_q + 1'b1;
      end
      if (tail_done) pay_cnt_q <= '0;
      case (st_q)
        ST_RX: if (accept && in_last_i) st_q <= ST_EVAL;
        ST_EVAL: begin
          idx_q <= '0; flush_n_q <= ev_flush; gen_q <= ev_gen;
          if (ev_gen) begin
            seq_use_q <= seq_ctr_q;
            seq_ctr_q <= seq_ctr_q + 1'b1;
            lsdu_q    <= LSDU_W'(ev_payload + CNT_W'(4));
          end else begin
            seq_use_q <= {hold_bytes[7:0], hold_bytes[15:8]};
          end
          st_q <= (ev_flush != '0) ? ST_FLUSH : (ev_gen ? ST_TRL : ST_CRC);
        end
        ST_FLUSH: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == flush_n_q - 3'd1) begin
            idx_q <= '0;
            st_q  <= gen_q ? ST_TRL : ST_CRC;
          end
        end
        ST_TRL: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 3'(TRL_BYTES - 1)) begin idx_q <= '0; st_q <= ST_CRC; end
        end
        ST_CRC: begin
          idx_q <= idx_q + 1'b1;
          if (tail_done) begin idx_q <= '0; st_q <= bypass_q ? ST_RX : ST_LKP; end
        end
        ST_LKP: if (lkp_done_i) begin
          verdict_valid_o <= 1'b1;
          verdict_drop_o  <= lkp_hit_i;
          st_q <= ST_RX;
        end
        default: st_q <= ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_a_valid_o <= 1'b0; out_a_data_o <= '0; out_a_last_o <= 1'b0;
      out_b_valid_o <= 1'b0; out_b_data_o <= '0; out_b_last_o <= 1'b0;
    end else begin
      out_a_valid_o <= emit;
      out_a_data_o  <= emit_byte[0];
      out_a_last_o  <= emit && is_last;
      out_b_valid_o <= emit && !bypass_q;
      out_b_data_o  <= emit_byte[1];
      out_b_last_o  <= emit && is_last && !bypass_q;
    end
  end
endmodule

// File: rtl/prp_trailer_chk.sv
`timescale 1ns/1ps
module prp_trailer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic in_last_i,
  input logic out_a_valid_o,
  input logic out_a_last_o,
  input logic out_b_valid_o,
  input logic out_b_last_o,
  input logic lkp_req_o,
  input logic lkp_done_i,
  input logic verdict_valid_o
);
  // R2: copy B never runs ahead of or apart from copy A
  a_r2_b_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_b_valid_o |-> (out_a_valid_o && (out_b_last_o == out_a_last_o)));
  a_r7_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_a_last_o |-> out_a_valid_o);
  a_r8_req_after_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lkp_req_o) |-> out_a_last_o);
  a_r8_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_o && !lkp_done_i) |=> lkp_req_o);
  a_r9_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_o && lkp_done_i) |=> !lkp_req_o);
  a_r9_verdict_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> $past(lkp_req_o && lkp_done_i));
  a_r11_eof_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o);
  a_r11_lookup_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_o |-> !in_ready_o);
endmodule

bind prp_trailer_handler prp_trailer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_last_i(in_last_i), .out_a_valid_o(out_a_valid_o), .out_a_last_o(out_a_last_o),
  .out_b_valid_o(out_b_valid_o), .out_b_last_o(out_b_last_o), .lkp_req_o(lkp_req_o),
  .lkp_done_i(lkp_done_i), .verdict_valid_o(verdict_valid_o)
);

// File: tb/prp_trailer_handler_bench.sv
`timescale 1ns/1ps
module prp_trailer_handler_bench;
  typedef logic [7:0] bq_t [$];
  localparam int K_CPU = 0, K_OK = 1, K_BAD = 2, K_BYP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic bypass = 0, in_valid = 0, in_last = 0, lkp_done = 0, lkp_hit = 0;
  logic [7:0] in_data = 0;
  logic [2:0] src_port = 0;
  logic [47:0] src_mac = 0;
  logic in_ready, a_v, a_l, b_v, b_l, lkp_req, v_v, v_d;
  logic [7:0] a_d, b_d;
  logic [63:0] lkp_key;

  prp_trailer_handler u_prp_trailer_handler (
    .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .src_port_i(src_port), .src_mac_i(src_mac),
    .out_a_valid_o(a_v), .out_a_data_o(a_d), .out_a_last_o(a_l),
    .out_b_valid_o(b_v), .out_b_data_o(b_d), .out_b_last_o(b_l),
    .lkp_req_o(lkp_req), .lkp_key_o(lkp_key), .lkp_done_i(lkp_done),
    .lkp_hit_i(lkp_hit), .verdict_valid_o(v_v), .verdict_drop_o(v_d)
  );

  int checks = 0, errors = 0, verdicts = 0, a_last_at = -1, b_last_at = -1;
  bit finished = 0;
  bq_t got_a, got_b;
  logic [15:0] exp_seq = 16'd1;

  always @(negedge clk) if (rst_n) begin
    if (a_v) begin got_a.push_back(a_d); if (a_l) a_last_at = got_a.size() - 1; end
    if (b_v) begin got_b.push_back(b_d); if (b_l) b_last_at = got_b.size() - 1; end
    if (v_v) verdicts++;
  end

  function automatic bq_t with_fcs(bq_t q);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      c ^= {24'd0, q[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) q.push_back(c[k*8 +: 8]);
    return q;
  endfunction

  function automatic logic [7:0] at(bq_t q, int i);
    return (i >= 0 && i < q.size()) ? q[i] : 8'hxx;
  endfunction

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_stream(string req, string what, bq_t got, bq_t exp);
    int bad = -1;
    checks++;
    for (int i = 0; i < exp.size() && bad < 0; i++) if (at(got, i) !== exp[i]) bad = i;
    if (bad < 0 && got.size() != exp.size()) bad = exp.size();
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s %s: byte %0d got %h expected %h (sizes %0d/%0d)", req, what, bad,
               at(got, bad), at(exp, bad), got.size(), exp.size());
    end
  endtask

  task automatic run_frame(int kind, bq_t body, logic [47:0] mac, logic [2:0] port, bit hit);
    bq_t fwd, ea, eb;
    bit gen = 0;
    int n = body.size();
    logic [15:0] s = 0;
    logic [11:0] lsdu = 0;
    string req;
    int v0, w;
    if (kind == K_CPU) port = 0;
    req = (kind == K_CPU) ? "R2" : (kind == K_OK) ? "R5" : (kind == K_BAD) ? "R6" : "R10";
    fwd = body;
    if (kind == K_CPU) gen = 1;
    else if (kind == K_OK) s = {body[n-6], body[n-5]};
    else if (kind == K_BAD) begin
      gen = 1;
      fwd = {};
      for (int i = 0; i < n - 6; i++) fwd.push_back(body[i]);
    end
    ea = fwd; eb = fwd;
    if (gen) begin
      s = exp_seq; exp_seq++;
      lsdu = 12'(fwd.size() + 4);
      ea.push_back(s[15:8]); ea.push_back(s[7:0]); ea.push_back({4'hA, lsdu[11:8]});
      eb.push_back(s[15:8]); eb.push_back(s[7:0]); eb.push_back({4'hB, lsdu[11:8]});
      foreach (ea[i]) ; // no-op keeps loop form uniform
      ea.push_back(lsdu[7:0]); ea.push_back(8'h88); ea.push_back(8'hFB);
      eb.push_back(lsdu[7:0]); eb.push_back(8'h88); eb.push_back(8'hFB);
    end
    ea = with_fcs(ea); eb = with_fcs(eb);
    got_a = {}; got_b = {}; a_last_at = -1; b_last_at = -1;
    v0 = verdicts;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 3) == 0) begin @(negedge clk); in_valid = 0; end
      @(negedge clk);
      in_valid = 1; in_data = body[i]; in_last = (i == n - 1);
      // R12: sideband only meaningful with the first byte
      bypass   = (i == 0) ? (kind == K_BYP) : 1'($urandom);
      src_port = (i == 0) ? port : 3'($urandom);
      src_mac  = (i == 0) ? mac : {$urandom, $urandom};
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    if (kind != K_BYP) begin
      w = 0;
      while (!lkp_req && w < 200) begin @(negedge clk); w++; end
      check("R8", "lookup request raised", lkp_req, 1);
      check("R12", "lookup key {mac,seq}", lkp_key, {mac, s});
      check("R11", "input stalled during lookup", in_ready, 0);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        check("R8", "request held until answer", lkp_req, 1);
      end
      lkp_done = 1; lkp_hit = hit;
      @(negedge clk);
      lkp_done = 0;
      check("R9", "verdict pulse", v_v, 1);
      check("R9", "verdict drop", v_d, hit);
      check("R9", "request released", lkp_req, 0);
      @(negedge clk);
      check("R9", "single verdict per frame", verdicts - v0, 1);
    end else begin
      w = 0;
      while (!in_ready && w < 200) begin @(negedge clk); w++; end
      repeat (3) @(negedge clk);
      check("R10", "no verdict in bypass", verdicts - v0, 0);
      check("R10", "output B silent", got_b.size(), 0);
      check("R10", "no lookup in bypass", lkp_req, 0);
    end
    check_stream(req, "output A stream", got_a, ea);
    if (kind != K_BYP) check_stream(req, "output B stream", got_b, eb);
    check_stream("R7", "CRC tail A", got_a.size() >= 4 ? got_a[$-3:$] : got_a,
                 ea[$-3:$]);
    check("R7", "last flag on final byte A", a_last_at, ea.size() - 1);
    if (kind != K_BYP) check("R7", "last flag on final byte B", b_last_at, eb.size() - 1);
    if (gen) begin
      int b = fwd.size();
      check("R3", "sequence in copy A", {at(got_a, b), at(got_a, b+1)}, s);
      check("R3", "sequence in copy B", {at(got_b, b), at(got_b, b+1)}, s);
      check("R2", "LAN id copy A", at(got_a, b+2) >> 4, 4'hA);
      check("R2", "LAN id copy B", at(got_b, b+2) >> 4, 4'hB);
      check("R4", "size field", {at(got_a, b+2) & 8'h0F, at(got_a, b+3)}, lsdu);
    end
  endtask

  function automatic bq_t rnd_bytes(int n);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom_range(0, 255)));
    return q;
  endfunction

  function automatic bq_t ok_body(int pay, logic [15:0] s);
    bq_t q = rnd_bytes(pay);
    q.push_back(s[15:8]); q.push_back(s[7:0]);
    q.push_back(8'($urandom)); q.push_back(8'($urandom));
    q.push_back(8'h88); q.push_back(8'hFB);
    return q;
  endfunction

  function automatic bq_t bad_body(int n);
    bq_t q = rnd_bytes(n);
    if (q[n-1] == 8'hFB) q[n-1] = 8'h00;
    return q;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ready after reset", in_ready, 1);
    check("R1", "outputs idle", {a_v, b_v}, 0);
    check("R1", "no lookup or verdict", {lkp_req, v_v}, 0);
    run_frame(K_CPU, '{8'h5A}, 48'h0011_2233_4455, 0, 0);
    run_frame(K_CPU, rnd_bytes(10), 48'hA1A2_A3A4_A5A6, 0, 0);
    run_frame(K_OK, ok_body(4, 16'h1234), 48'h0202_0202_0202, 3'd1, 1);
    run_frame(K_OK, ok_body(0, 16'hBEEF), 48'h0303_0303_0303, 3'd5, 0);
    run_frame(K_BAD, bad_body(12), 48'h0404_0404_0404, 3'd2, 0);
    run_frame(K_BAD, bad_body(3), 48'h0505_0505_0505, 3'd7, 0);
    run_frame(K_BAD, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h88, 8'hFA}, 48'h06, 3'd3, 1);
    run_frame(K_BYP, rnd_bytes(9), 48'h0707_0707_0707, 3'd4, 0);
    run_frame(K_CPU, rnd_bytes(7), 48'h0808_0808_0808, 0, 1);
    for (int f = 0; f < 40; f++) begin
      int kind = $urandom_range(0, 3);
      bq_t body;
      case (kind)
        K_OK:    body = ok_body($urandom_range(0, 20), 16'($urandom));
        K_BAD:   body = bad_body($urandom_range(1, 24));
        default: body = rnd_bytes($urandom_range(1, 30));
      endcase
      run_frame(kind, body, {$urandom, $urandom}, 3'($urandom_range(1, 7)),
                1'($urandom));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule